// File: doc/BRIEF.md
# Supervisory Watchdog Timer with Byte Register Port

This block is a seconds-granular watchdog for a board management controller. Software reaches it through a byte-wide register port with three locations: an options and enable register, a reload value in whole seconds, and a kick location that only responds to one code. While enabled, the counter steps down on each pulse of a one-second tick input. When the count is zero it expires. On expiry it can raise a board reset request, pull a separate active-low timeout line, and mark that the failsafe boot path must be taken. All three stay latched until the next board reset.

Two enable bits choose between a plain mode and a recovery mode, and only the recovery mode marks the failsafe path. A lock bit freezes the options register until reset. At power-on a configuration input decides whether the watchdog starts armed, so that it supervises boot-up. The usual software sequence is to disarm, write the reload value, kick, and then arm with all options in a single write. Loading a reload value of zero and then arming forces an expiry on purpose.

Top module: `wdt_supervisor`

## Requirements
- R1: While `rst_n` is low, the control register loads 0x42 (recovery enable plus reset option) if `cfg_boot_en` is 1 and 0x00 otherwise. The timeout register and the counter load `BOOT_SECS` (default 10). After reset `sys_rst_req`=0, `wd_timeout_n`=1 and `failsafe_sel`=0.
- R2: Address 0 reads control, address 1 reads timeout, address 2 (kick) reads 0x00, and address 3 reads 0x00. Reads are combinational. Control bits 3 to 5 always read as zero.
- R3: Once control bit 2 (lock) is set, writes to address 0 leave control unchanged until the next reset. Timeout writes are still accepted.
- R4: Writing exactly 0x6b to address 2 reloads the counter from the timeout register. Any other value written there has no effect on the countdown.
- R5: The counter decrements by one per cycle in which `tick_1s` is high and control bit 0 or bit 1 is set. With both bits clear it holds.
- R6: When the counter is zero while enabled, expiry is registered one clock later. `sys_rst_req` rises if control bit 6 is set, and `wd_timeout_n` falls if control bit 7 is set.
- R7: `failsafe_sel` rises on expiry only if control bit 1 was set at that moment.
- R8: Expiry outputs stay latched until reset, whatever is written afterwards.
- R9: With a timeout of 0 loaded by a kick, setting an enable bit causes expiry with no tick.
- R10: A valid kick in the same cycle as a tick reloads the counter, and the tick is lost.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low board reset |
| cfg_boot_en | input | 1 | Non-volatile setting: arm in recovery mode out of reset |
| tick_1s | input | 1 | One-cycle pulse once per second |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| sys_rst_req | output | 1 | Latched board reset request |
| wd_timeout_n | output | 1 | Latched active-low timeout line |
| failsafe_sel | output | 1 | Latched failsafe boot selection |

## Verification
A kick and a seconds tick can land in the same clock, and the reload must win. The bench provokes this by driving a valid kick and a tick together when one second is left. It then counts the full reload interval again before expiry, so any lost reload or extra decrement shows up as early or late expiry. Sweeps over reload values, both enable modes and all option pairs check that expiry falls exactly on the programmed tick.

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
  parameter int DW = 8,
  parameter logic [DW-1:0] KICK_CODE = 8'h6b,
  parameter logic [DW-1:0] BOOT_SECS = 8'd10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_boot_en,
  input  logic          tick_1s,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          sys_rst_req,
  output logic          wd_timeout_n,
  output logic          failsafe_sel
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_TMO  = 2'd1;
  localparam logic [1:0] A_KICK = 2'd2;
  localparam logic [DW-1:0] CTRL_MASK = DW'(8'hC7);
  localparam logic [DW-1:0] CTRL_BOOT = DW'(8'h42);

  logic [DW-1:0] ctrl_q, tmo_q, cnt_q;
  logic          exp_q, rst_q, line_q, fs_q;

  wire armed     = ctrl_q[0] | ctrl_q[1];
  wire locked    = ctrl_q[2];
  wire ctrl_wr   = reg_we && reg_addr == A_CTRL && !locked;
  wire tmo_wr    = reg_we && reg_addr == A_TMO;
  wire kick      = reg_we && reg_addr == A_KICK && reg_wdata == KICK_CODE;
  wire exp_evt   = armed && cnt_q == '0 && !exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= cfg_boot_en ? CTRL_BOOT : '0;
      tmo_q  <= BOOT_SECS;
    end else begin
      if (ctrl_wr) ctrl_q <= reg_wdata & CTRL_MASK;
      if (tmo_wr)  tmo_q  <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= BOOT_SECS;
    else if (kick)
      cnt_q <= tmo_q;
    else if (armed && tick_1s && cnt_q != '0 && !exp_q)
      cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q  <= 1'b0;
      rst_q  <= 1'b0;
      line_q <= 1'b0;
      fs_q   <= 1'b0;
    end else if (exp_evt) begin
      exp_q  <= 1'b1;
      rst_q  <= ctrl_q[6];
      line_q <= ctrl_q[7];
      fs_q   <= ctrl_q[1];
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_TMO:   reg_rdata = tmo_q;
      default: reg_rdata = '0;
    endcase
  end

  assign sys_rst_req  = rst_q;
  assign wd_timeout_n = ~line_q;
  assign failsafe_sel = fs_q;
endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk #(
  parameter int DW = 8,
  parameter logic [DW-1:0] KICK_CODE = 8'h6b
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_1s,
  input logic          reg_we,
  input logic [1:0]    reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] ctrl_q,
  input logic [DW-1:0] tmo_q,
  input logic [DW-1:0] cnt_q,
  input logic          sys_rst_req,
  input logic          wd_timeout_n,
  input logic          failsafe_sel
);
  wire kick_now = reg_we && reg_addr == 2'd2 && reg_wdata == KICK_CODE;

  assert_lock_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[2] |=> $stable(ctrl_q));

  assert_kick_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    kick_now |=> cnt_q == $past(tmo_q));

  assert_hold_without_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!kick_now && !tick_1s) |=> $stable(cnt_q));

  assert_line_needs_opt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_timeout_n) |-> $past(ctrl_q[7]));

  assert_reset_needs_opt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(ctrl_q[6]));

  assert_failsafe_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(failsafe_sel) |-> $past(ctrl_q[1]));

  assert_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_req || !wd_timeout_n || failsafe_sel) |=>
      $stable({sys_rst_req, wd_timeout_n, failsafe_sel}));

  always_comb
    if (rst_n) assert_reserved_zero_R2: assert (ctrl_q[5:3] == 3'b000);
endmodule

bind wdt_supervisor wdt_supervisor_chk #(.DW(DW), .KICK_CODE(KICK_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ctrl_q(ctrl_q),
  .tmo_q(tmo_q), .cnt_q(cnt_q), .sys_rst_req(sys_rst_req),
  .wd_timeout_n(wd_timeout_n), .failsafe_sel(failsafe_sel));

// File: tb/sim_wdt_supervisor.sv
module sim_wdt_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] KICK = 8'h6b;

  logic clk = 0, rst_n = 0, cfg_boot_en = 0, tick_1s = 0, reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic sys_rst_req, wd_timeout_n, failsafe_sel;
  int n_run = 0, n_fail = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_supervisor u0 (.clk(clk), .rst_n(rst_n), .cfg_boot_en(cfg_boot_en),
    .tick_1s(tick_1s), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_rst_req(sys_rst_req),
    .wd_timeout_n(wd_timeout_n), .failsafe_sel(failsafe_sel));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {5'b0, sys_rst_req, ~wd_timeout_n, failsafe_sel};
  endfunction

  task automatic do_reset(logic cfg);
    @(negedge clk); rst_n = 0; cfg_boot_en = cfg;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1s = 1;
      @(negedge clk); tick_1s = 0;
    end
  endtask

  task automatic arm(logic [7:0] t, logic [7:0] c);
    wr(0, 8'h00); wr(1, t); wr(2, KICK); wr(0, c);
  endtask

  initial begin
    logic [7:0] v;
    // R1 boot-armed reset state and boot supervision
    do_reset(1);
    rd(0, v); chk("R1 ctrl boot", v, 8'h42);
    rd(1, v); chk("R1 tmo boot", v, 8'd10);
    chk("R1 outs idle", outs(), 8'h0);
    ticks(9); @(negedge clk); chk("R1 no early expiry", outs(), 8'h0);
    ticks(1); @(negedge clk); chk("R1 boot expiry", outs(), 8'h05);

    // R5 disabled holds
    do_reset(0);
    rd(0, v); chk("R1 ctrl off", v, 8'h00);
    ticks(20); @(negedge clk); chk("R5 disabled no expiry", outs(), 8'h0);

    // R2 readback
    wr(0, 8'h38); rd(0, v); chk("R2 reserved zero", v, 8'h00);
    wr(0, 8'hC0); rd(0, v); chk("R2 ctrl readback", v, 8'hC0);
    wr(1, 8'hA5); rd(1, v); chk("R2 tmo readback", v, 8'hA5);
    wr(2, KICK);  rd(2, v); chk("R2 kick reads zero", v, 8'h00);
    rd(3, v); chk("R2 addr3 zero", v, 8'h00);

    // R6 R7 sweep: timeout x mode x options
    for (int t = 1; t <= 5; t++)
      for (int m = 0; m < 2; m++)
        for (int o = 0; o < 4; o++) begin
          logic [7:0] c, e;
          c = (m ? 8'h02 : 8'h01) | (o[0] ? 8'h40 : 8'h0) | (o[1] ? 8'h80 : 8'h0);
          e = {5'b0, o[0], o[1], m[0]};
          do_reset(0);
          arm(t[7:0], c);
          ticks(t - 1); @(negedge clk);
          chk("R6 before expiry", outs(), 8'h0);
          ticks(1); @(negedge clk);
          chk("R6 R7 expiry outs", outs(), e);
        end

    // R3 lock
    do_reset(0);
    wr(0, 8'h05); wr(0, 8'h00); rd(0, v); chk("R3 locked ctrl", v, 8'h05);
    wr(1, 8'h33); rd(1, v); chk("R3 tmo still writable", v, 8'h33);
    do_reset(0);
    wr(0, 8'h01); wr(0, 8'h00); rd(0, v); chk("R3 unlocked after reset", v, 8'h00);

    // R4 wrong kick ignored, right kick reloads
    do_reset(0); arm(8'd4, 8'h41);
    ticks(2); wr(2, 8'h6a); ticks(2); @(negedge clk);
    chk("R4 bad kick ignored", outs(), 8'h04);
    do_reset(0); arm(8'd4, 8'h41);
    ticks(3); wr(2, KICK); ticks(3); @(negedge clk);
    chk("R4 kick reload no expiry", outs(), 8'h0);
    ticks(1); @(negedge clk); chk("R4 expiry after reload", outs(), 8'h04);

    // R8 latched
    wr(0, 8'h00); wr(2, KICK); ticks(2); @(negedge clk);
    chk("R8 latched", outs(), 8'h04);

    // R9 zero timeout forces expiry
    do_reset(0); arm(8'd0, 8'hC2); @(negedge clk);
    chk("R9 forced expiry", outs(), 8'h07);

    // R10 kick with tick in same cycle
    do_reset(0); arm(8'd3, 8'h41);
    ticks(2);
    @(negedge clk); reg_we = 1; reg_addr = 2; reg_wdata = KICK; tick_1s = 1;
    @(negedge clk); reg_we = 0; tick_1s = 0;
    ticks(2); @(negedge clk); chk("R10 reload wins", outs(), 8'h0);
    ticks(1); @(negedge clk); chk("R10 expiry after full", outs(), 8'h04);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule